// File: doc/BRIEF.md
# Multi-Vector Group Address Sequencer

This control block turns the operand fields of a multi-vector accumulate instruction into a short, timed series of register-file indices. A single start pulse captures the operands. The block then produces 2 or 4 iterations, one per clock. Each iteration carries three indices:

- the first-source vector register index;
- the multiplier vector register index;
- the accumulator array row that the iteration updates.

With each iteration the block also presents the index of the vector-select general register. The block does no arithmetic and holds no register-file storage. The datapath that owns those uses the indices to read and write its operands.

The accumulator array has one row per 8 bits of vector length. The rows are split into 2 or 4 equal partitions, one for each iteration, and each partition is one stride long. The first row is the 32-bit base value plus the offset, reduced modulo the stride. Each later iteration adds one stride, so it lands in the next partition. The source register index counts up by one per iteration and wraps from 31 to 0. Vector lengths are assumed legal: a power of two from 128 to 2048 bits. This keeps every stride a power of two, so the modulo is a mask.

The controller is a three-state machine:

- **IDLE**: waits for a start pulse. IDLE --start--> STEP, which loads the operands and clears the iteration count.
- **STEP**: presents one iteration per cycle. STEP --not last--> STEP advances the row by the stride, the source index by one and the iteration count by one. STEP --last--> FIN.
- **FIN**: raises done for one cycle. FIN --always--> IDLE.

Top module: `mvg_addr_seq`

## Requirements
- R1: During and right after reset the block is idle: busy, step valid and done are all 0.
- R2: A start pulse taken in IDLE gives a run of exactly N consecutive valid cycles, with step numbers 0 to N-1. The first valid cycle is the clock after the one that took start. N is 2 when grp4_i is 0 and 4 when grp4_i is 1.
- R3: The row of step 0 is (sel_base_i + offset_i, a 32-bit sum that wraps) modulo S, where S = (vl_bits_i / 8) / N. The row is always below vl_bits_i / 8.
- R4: Each later step's row is the previous step's row plus S.
- R5: On step r the source index is (src_field_i + r) modulo 32.
- R6: The multiplier index is the 4-bit mul_field_i with a zero in bit 4, so it is always in 0..15.
- R7: The select register index is 8 + sel_field_i: binary 010 followed by the 2-bit field.
- R8: Done is 1 for exactly one cycle. That cycle is the clock after the last valid step, and step valid is 0 during it.
- R9: A start pulse while the block is busy (STEP or FIN) is ignored. The current run continues unchanged and no extra run follows.
- R10: All operands are captured when start is taken. Changes on the operand inputs during a run have no effect on that run's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, honoured only in IDLE |
| grp4_i | input | 1 | Group count select: 0 for 2 iterations, 1 for 4 |
| vl_bits_i | input | VL_W (12) | Vector length in bits |
| sel_field_i | input | 2 | Vector-select register field |
| sel_base_i | input | 32 | Base value read from the vector-select register |
| offset_i | input | 3 | Row offset, 0 to 7 |
| src_field_i | input | 5 | First-source register field |
| mul_field_i | input | 4 | Multiplier register field |
| busy_o | output | 1 | High in STEP and FIN |
| step_valid_o | output | 1 | An iteration is presented this cycle |
| step_num_o | output | 2 | Iteration number r |
| sel_reg_o | output | 5 | Vector-select register index (8 to 11) |
| src_reg_o | output | 5 | First-source register index for this iteration |
| mul_reg_o | output | 5 | Multiplier register index (0 to 15) |
| row_o | output | ROW_W (8) | Accumulator array row for this iteration |
| done_o | output | 1 | One-cycle pulse after the last iteration |

## Verification
Iteration r of a run is due on the clock r+1 after the edge that takes start, and done is due on clock N+1. The bench therefore drives inputs on falling edges. A monitor on the same falling edges pops a scoreboard entry for every valid cycle, so a late, early or missing iteration shows up as a miscompare or as a leftover entry. The done pulse is checked on the exact falling edge N+1, and its clearing on N+2. A second start and scrambled operands are applied one cycle into each run, so R9 and R10 are judged on the outputs that follow.

// File: rtl/mvg_pkg.sv
package mvg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_e;

    // index of the vector-select register: fixed prefix 010 plus 2-bit field
    localparam logic [2:0] SEL_PREFIX = 3'b010;

    function automatic logic [1:0] last_step(input logic grp4);
        return grp4 ? 2'd3 : 2'd1;
    endfunction

endpackage

// File: rtl/mvg_stride_calc.sv
module mvg_stride_calc #(
    parameter int VL_W  = 12,
    localparam int ROW_W = VL_W - 4
) (
    input  logic [VL_W-1:0]  vl_bits_i,
    input  logic             grp4_i,
    output logic [ROW_W:0]   rows_o,
    output logic [ROW_W-1:0] stride_o,
    output logic [ROW_W-1:0] mask_o
);
    logic [ROW_W:0] part;

    // one row per byte of vector length
    assign rows_o = vl_bits_i[VL_W-1:3];

    generate
        if (ROW_W >= 2) begin : g_shift
            always_comb begin
                part = grp4_i ? (rows_o >> 2) : (rows_o >> 1);
            end
        end else begin : g_tiny
            always_comb begin
                part = rows_o >> 1;
            end
        end
    endgenerate

    assign stride_o = part[ROW_W-1:0];
    // stride is a power of two for every legal length
    assign mask_o   = stride_o - {{(ROW_W-1){1'b0}}, 1'b1};
endmodule

// File: rtl/mvg_row_gen.sv
module mvg_row_gen #(
    parameter int ROW_W  = 8,
    parameter int BASE_W = 32,
    parameter int OFF_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [BASE_W-1:0] base_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [ROW_W-1:0]  stride_i,
    input  logic [ROW_W-1:0]  mask_i,
    output logic [ROW_W-1:0]  row_o,
    output logic [ROW_W-1:0]  stride_o
);
    logic [BASE_W-1:0] sum;
    logic [ROW_W-1:0]  row_q;
    logic [ROW_W-1:0]  stride_q;

    assign sum = base_i + {{(BASE_W-OFF_W){1'b0}}, off_i};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q    <= '0;
            stride_q <= '0;
        end else if (load_i) begin
            row_q    <= sum[ROW_W-1:0] & mask_i;
            stride_q <= stride_i;
        end else if (step_i) begin
            row_q    <= row_q + stride_q;
        end
    end

    assign row_o    = row_q;
    assign stride_o = stride_q;
endmodule

// File: rtl/mvg_src_gen.sv
module mvg_src_gen #(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [REG_W-1:0] field_i,
    output logic [REG_W-1:0] idx_o
);
    logic [REG_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       idx_q <= '0;
        else if (load_i)  idx_q <= field_i;
        else if (step_i)  idx_q <= idx_q + {{(REG_W-1){1'b0}}, 1'b1}; // wraps at 2**REG_W
    end

    assign idx_o = idx_q;
endmodule

// File: rtl/mvg_addr_seq.sv
module mvg_addr_seq
    import mvg_pkg::*;
#(
    parameter int MAX_VL = 2048,
    localparam int VL_W  = $clog2(MAX_VL) + 1,
    localparam int ROW_W = VL_W - 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             grp4_i,
    input  logic [VL_W-1:0]  vl_bits_i,
    input  logic [1:0]       sel_field_i,
    input  logic [31:0]      sel_base_i,
    input  logic [2:0]       offset_i,
    input  logic [4:0]       src_field_i,
    input  logic [3:0]       mul_field_i,
    output logic             busy_o,
    output logic             step_valid_o,
    output logic [1:0]       step_num_o,
    output logic [4:0]       sel_reg_o,
    output logic [4:0]       src_reg_o,
    output logic [4:0]       mul_reg_o,
    output logic [ROW_W-1:0] row_o,
    output logic             done_o
);
    seq_state_e state_q, state_d;

    logic [1:0]       step_q;
    logic             grp4_q;
    logic [1:0]       sel_q;
    logic [3:0]       mul_q;
    logic [ROW_W:0]   rows_q;
    logic             load, advance, at_last;
    logic [ROW_W:0]   rows_w;
    logic [ROW_W-1:0] stride_w, mask_w, stride_held;

    mvg_stride_calc #(.VL_W(VL_W)) u_stride (
        .vl_bits_i (vl_bits_i),
        .grp4_i    (grp4_i),
        .rows_o    (rows_w),
        .stride_o  (stride_w),
        .mask_o    (mask_w)
    );

    mvg_row_gen #(.ROW_W(ROW_W), .BASE_W(32), .OFF_W(3)) u_row (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .step_i   (advance),
        .base_i   (sel_base_i),
        .off_i    (offset_i),
        .stride_i (stride_w),
        .mask_i   (mask_w),
        .row_o    (row_o),
        .stride_o (stride_held)
    );

    mvg_src_gen #(.REG_W(5)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .step_i  (advance),
        .field_i (src_field_i),
        .idx_o   (src_reg_o)
    );

    assign at_last = (step_q == last_step(grp4_q));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and control outputs
    always_comb begin
        state_d      = state_q;
        load         = 1'b0;
        advance      = 1'b0;
        step_valid_o = 1'b0;
        done_o       = 1'b0;
        busy_o       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    load    = 1'b1;
                    state_d = ST_STEP;
                end
            end
            ST_STEP: begin
                busy_o       = 1'b1;
                step_valid_o = 1'b1;
                if (at_last) state_d = ST_FIN;
                else         advance = 1'b1;
            end
            ST_FIN: begin
                busy_o  = 1'b1;
                done_o  = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // captured operands and iteration count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            grp4_q <= 1'b0;
            sel_q  <= '0;
            mul_q  <= '0;
            rows_q <= '0;
        end else if (load) begin
            step_q <= '0;
            grp4_q <= grp4_i;
            sel_q  <= sel_field_i;
            mul_q  <= mul_field_i;
            rows_q <= rows_w;
        end else if (advance) begin
            step_q <= step_q + 2'd1;
        end
    end

    assign step_num_o = step_q;
    assign sel_reg_o  = {SEL_PREFIX, sel_q};
    assign mul_reg_o  = {1'b0, mul_q};

    // ---------------- assertions ----------------
    assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid_o && at_last) |=> (done_o && !step_valid_o));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_row_stride_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid_o && $past(step_valid_o)) |-> (row_o == $past(row_o) + stride_held));

    assert_src_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid_o && $past(step_valid_o)) |-> (src_reg_o == $past(src_reg_o) + 5'd1));

    assert_row_in_array_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid_o |-> ({1'b0, row_o} < rows_q));

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid_o && !at_last) |=> (step_valid_o && step_num_o == $past(step_num_o) + 2'd1));

    assert_first_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (step_valid_o && step_num_o == 2'd0));
endmodule

// File: tb/tb_mvg_addr_seq.sv
module tb_mvg_addr_seq;
    localparam int VL_W  = 12;
    localparam int ROW_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             grp4_i = 1'b0;
    logic [VL_W-1:0]  vl_bits_i = 12'd128;
    logic [1:0]       sel_field_i = '0;
    logic [31:0]      sel_base_i = '0;
    logic [2:0]       offset_i = '0;
    logic [4:0]       src_field_i = '0;
    logic [3:0]       mul_field_i = '0;
    logic             busy_o, step_valid_o, done_o;
    logic [1:0]       step_num_o;
    logic [4:0]       sel_reg_o, src_reg_o, mul_reg_o;
    logic [ROW_W-1:0] row_o;

    typedef struct packed {
        logic [1:0]       num;
        logic [4:0]       sel;
        logic [4:0]       src;
        logic [4:0]       mul;
        logic [ROW_W-1:0] row;
    } item_t;

    item_t exp_q[$];
    int    applied = 0;
    int    miscompares = 0;
    bit    finished = 1'b0;

    always #2.5 clk = ~clk;

    mvg_addr_seq #(.MAX_VL(2048)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .grp4_i(grp4_i),
        .vl_bits_i(vl_bits_i), .sel_field_i(sel_field_i), .sel_base_i(sel_base_i),
        .offset_i(offset_i), .src_field_i(src_field_i), .mul_field_i(mul_field_i),
        .busy_o(busy_o), .step_valid_o(step_valid_o), .step_num_o(step_num_o),
        .sel_reg_o(sel_reg_o), .src_reg_o(src_reg_o), .mul_reg_o(mul_reg_o),
        .row_o(row_o), .done_o(done_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: one scoreboard entry per valid cycle (R2, R3, R4, R5, R6, R7, R10)
    always @(negedge clk) begin
        if (rst_n && step_valid_o) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected step", {62'd0, step_num_o}, 64'hFFFF);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                check("R2 step number", {62'd0, step_num_o}, {62'd0, e.num});
                check("R7 select index", {59'd0, sel_reg_o}, {59'd0, e.sel});
                check("R5 source index", {59'd0, src_reg_o}, {59'd0, e.src});
                check("R6 multiplier index", {59'd0, mul_reg_o}, {59'd0, e.mul});
                check("R3 R4 row", {56'd0, row_o}, {56'd0, e.row});
            end
        end
    end

    // driver: computes expectations from the requirements, runs one sequence
    task automatic run_seq(input logic g4, input int vl, input logic [1:0] sf,
                           input logic [31:0] base, input logic [2:0] off,
                           input logic [4:0] srcf, input logic [3:0] mulf);
        int n, rows, stride;
        logic [31:0] sum;
        n      = g4 ? 4 : 2;
        rows   = vl / 8;
        stride = rows / n;
        sum    = base + {29'd0, off};
        for (int r = 0; r < n; r++) begin
            item_t e;
            e.num = r[1:0];
            e.sel = 5'd8 + {3'd0, sf};
            e.src = srcf + r[4:0];
            e.mul = {1'b0, mulf};
            e.row = ROW_W'((int'(sum % stride)) + r * stride);
            exp_q.push_back(e);
        end
        @(negedge clk);
        grp4_i = g4; vl_bits_i = vl[VL_W-1:0]; sel_field_i = sf; sel_base_i = base;
        offset_i = off; src_field_i = srcf; mul_field_i = mulf; start_i = 1'b1;
        @(negedge clk);
        // R9 R10: second start and scrambled operands while busy
        start_i = 1'b1; grp4_i = ~g4; vl_bits_i = 12'd2048; sel_field_i = ~sf;
        sel_base_i = ~base; offset_i = ~off; src_field_i = ~srcf; mul_field_i = ~mulf;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 2; k < n; k++) @(negedge clk);
        // falling edge n+1: done pulse (R8)
        @(negedge clk);
        check("R8 done high", {63'd0, done_o}, 64'd1);
        check("R8 no valid with done", {63'd0, step_valid_o}, 64'd0);
        @(negedge clk);
        check("R8 done single", {63'd0, done_o}, 64'd0);
        check("R9 no extra run", {63'd0, busy_o}, 64'd0);
        check("R2 all steps seen", exp_q.size(), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy in reset", {63'd0, busy_o}, 64'd0);
        check("R1 valid in reset", {63'd0, step_valid_o}, 64'd0);
        check("R1 done in reset", {63'd0, done_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {62'd0, busy_o, step_valid_o}, 64'd0);
        run_seq(1'b0, 128, 2'd0, 32'd5, 3'd2, 5'd3, 4'd9);
        run_seq(1'b1, 128, 2'd3, 32'd13, 3'd7, 5'd30, 4'd15);
        run_seq(1'b1, 2048, 2'd1, 32'hFFFF_FFFF, 3'd7, 5'd31, 4'd0);
        run_seq(1'b0, 2048, 2'd2, 32'h1234_5677, 3'd1, 5'd31, 4'd7);
        run_seq(1'b1, 512, 2'd2, 32'd100, 3'd0, 5'd0, 4'd4);
        run_seq(1'b0, 256, 2'd1, 32'h8000_000F, 3'd6, 5'd16, 4'd12);
        for (int i = 0; i < 6; i++)
            run_seq(i[0], 128 << (i % 5), i[1:0], 32'hA5A5_0000 + i * 977,
                    3'(i * 3), 5'(i * 7 + 28), 4'(i * 5));
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end
endmodule